// File: doc/BRIEF.md
# Serial-Paced Single-Step Boot Loader

This block lets a 6502-class CPU boot with no ROM. Out of reset it is in boot mode. A serial receiver's byte-ready flag drives the CPU ready line, so the CPU advances exactly one bus cycle for each byte that arrives on the serial line. Every CPU read cycle during boot mode is answered with the most recently received byte. A host can therefore feed the CPU a blind instruction stream that copies a small file loader into RAM and then jumps to it.

Once the loader runs, it writes a control register to leave boot mode. From then on the ready line stays high. The block then acts as an ordinary memory-mapped serial receive port, with a data register, a status register and the control register, all selected by chip-select and a two-bit offset.

A CPU bus cycle is marked by a one-clock completion strobe `stb_i`, given at the end of that cycle. The receiver runs at a fixed 115200 baud with 8 data bits, no parity and one stop bit. It oversamples 16 times per bit.

Top module: `serial_step_boot`

## Requirements
- R1: The receiver accepts 8N1 frames at 115200 baud, least significant data bit first. It finds the falling start edge with a 16x oversampling tick, checks the start bit again at its middle, and samples every data bit and the stop bit near its centre.
- R2: In boot mode, `rdy_o` equals the byte-ready flag. It is low after reset and goes high only once a complete byte has been received.
- R3: In boot mode, every read cycle (`rw_i`=1) has `rdata_oe_o`=1 and `rdata_o` equal to the latest received byte, whatever the values of `cs_i` and `addr_i`.
- R4: In boot mode, a completion strobe clears the byte-ready flag. `rdy_o` is therefore low on the clock after the strobe, until the next byte completes.
- R5: In boot mode, a write cycle (`rw_i`=0) leaves `rdata_oe_o` low. The block does not drive the data bus.
- R6: A frame whose stop bit samples low is discarded. It does not set byte-ready and does not change the data byte, and it sets the framing-error flag.
- R7: A byte that completes while byte-ready is still set replaces the held byte and sets the overrun flag.
- R8: In normal mode, a read at offset 0 returns the held byte, and its completion strobe clears byte-ready.
- R9: In normal mode, a read at offset 1 returns the status byte: bit 0 is byte-ready, bit 1 is framing error, bit 2 is overrun, and bits 7..3 are 0. The completion strobe of that read clears the framing-error and overrun flags.
- R10: A selected write at offset 2 with data bit 7 set leaves boot mode (`boot_o` falls). A write with bit 7 clear has no effect on the mode. Nothing but reset returns the block to boot mode.
- R11: In normal mode, `rdy_o` is held high, and `rdata_oe_o` is high only for a selected read (`cs_i`=1 and `rw_i`=1).
- R12: Reset puts the block in boot mode with `rdy_o`=0 and all flags clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Serial receive line, idle high |
| cs_i | input | 1 | Chip select for normal-mode register access |
| rw_i | input | 1 | CPU direction, 1 = read |
| addr_i | input | 2 | Register offset |
| stb_i | input | 1 | One-clock pulse marking completion of a CPU bus cycle |
| wdata_i | input | 8 | CPU write data |
| rdata_o | output | 8 | Data driven toward the CPU bus |
| rdata_oe_o | output | 1 | Enable for driving rdata_o onto the bus |
| rdy_o | output | 1 | CPU ready line |
| boot_o | output | 1 | High while in boot mode |

## Verification
Bus-side results depend on timing as follows:
- `rdata_o` and `rdata_oe_o` follow the bus inputs in the same cycle. The bench checks them one time unit after it drives a cycle.
- Flag clears and the mode change appear on the clock after the strobe. The bench updates its model just after that edge.
- A received byte becomes visible at some cycle inside its own frame, after the stop-bit centre plus two synchroniser stages.

To keep to this, the bench treats `rdy_o` and the boot-mode data bus as undefined only while a frame is in flight. It applies the byte to its reference model when the frame ends, and it compares the ports against the model at every falling clock edge outside that window.

// File: rtl/sboot_pkg.sv
package sboot_pkg;

    localparam int OVS     = 16;   // oversampling ticks per bit
    localparam int DBITS   = 8;    // data bits per frame
    localparam int BUS_W   = 8;

    localparam logic [1:0] OFS_DATA = 2'd0;
    localparam logic [1:0] OFS_STAT = 2'd1;
    localparam logic [1:0] OFS_CTRL = 2'd2;

    localparam logic [BUS_W-1:0] LEAVE_BOOT_MASK = 8'h80;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic [4:0] pad;
        logic       overrun;
        logic       frame_err;
        logic       ready;
    } status_t;

    function automatic int calc_div(input int clk_hz, input int baud);
        int d;
        d = clk_hz / (baud * OVS);
        return (d < 1) ? 1 : d;
    endfunction

endpackage

// File: rtl/sboot_tick.sv
module sboot_tick #(
    parameter int DIV = 54
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;

    logic [W-1:0] cnt_q;

    assign tick_o = (cnt_q == W'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || tick_o) cnt_q <= '0;
        else               cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/sboot_rx_frame.sv
module sboot_rx_frame
    import sboot_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             rx_i,
    output logic [DBITS-1:0] byte_o,
    output logic             valid_o,
    output logic             ferr_o
);
    localparam int IW = $clog2(DBITS);
    localparam logic [3:0] MID  = 4'(OVS / 2 - 1);
    localparam logic [3:0] LAST = 4'(OVS - 1);

    logic [1:0]       sync_q;
    logic             rxd;
    rx_state_e        state_q;
    logic [3:0]       cnt_q;
    logic [IW-1:0]    idx_q;
    logic [DBITS-1:0] shift_q;

    assign rxd    = sync_q[1];
    assign byte_o = shift_q;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= 2'b11;
        else     sync_q <= {sync_q[0], rx_i};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            shift_q <= '0;
            valid_o <= 1'b0;
            ferr_o  <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            ferr_o  <= 1'b0;
            if (tick_i) begin
                case (state_q)
                    RX_IDLE: begin
                        if (!rxd) begin
                            state_q <= RX_START;
                            cnt_q   <= '0;
                        end
                    end
                    RX_START: begin
                        if (cnt_q == MID) begin
                            cnt_q <= '0;
                            idx_q <= '0;
                            state_q <= rxd ? RX_IDLE : RX_DATA;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (cnt_q == LAST) begin
                            cnt_q   <= '0;
                            shift_q <= {rxd, shift_q[DBITS-1:1]};
                            if (idx_q == IW'(DBITS - 1)) state_q <= RX_STOP;
                            else                         idx_q   <= idx_q + 1'b1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (cnt_q == LAST) begin
                            cnt_q   <= '0;
                            state_q <= RX_IDLE;
                            if (rxd) valid_o <= 1'b1;
                            else     ferr_o  <= 1'b1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: state_q <= RX_IDLE;
                endcase
            end
        end
    end

    // R1: a completed byte is reported for one clock only
    a_r1_valid_single: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    // R6: a frame is either accepted or rejected, never both
    a_r6_ferr_excl: assert property (@(posedge clk) disable iff (rst)
        !(valid_o && ferr_o));
endmodule

// File: rtl/sboot_hold.sv
module sboot_hold
    import sboot_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [DBITS-1:0] byte_i,
    input  logic             valid_i,
    input  logic             ferr_i,
    input  logic             clr_ready_i,
    input  logic             clr_err_i,
    output logic [DBITS-1:0] data_o,
    output status_t          status_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data_o   <= '0;
            status_o <= '0;
        end else begin
            if (valid_i) begin
                data_o          <= byte_i;
                status_o.ready  <= 1'b1;
            end else if (clr_ready_i) begin
                status_o.ready  <= 1'b0;
            end

            if (valid_i && status_o.ready && !clr_ready_i) status_o.overrun <= 1'b1;
            else if (clr_err_i)                            status_o.overrun <= 1'b0;

            if (ferr_i)         status_o.frame_err <= 1'b1;
            else if (clr_err_i) status_o.frame_err <= 1'b0;
        end
    end

    // R7: an unconsumed byte that is overwritten raises overrun
    a_r7_overrun_set: assert property (@(posedge clk) disable iff (rst)
        (valid_i && status_o.ready && !clr_ready_i) |=> status_o.overrun);
endmodule

// File: rtl/serial_step_boot.sv
module serial_step_boot
    import sboot_pkg::*;
#(
    parameter int CLK_HZ = 100_000_000,
    parameter int BAUD   = 115_200
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_i,
    input  logic             cs_i,
    input  logic             rw_i,
    input  logic [1:0]       addr_i,
    input  logic             stb_i,
    input  logic [BUS_W-1:0] wdata_i,
    output logic [BUS_W-1:0] rdata_o,
    output logic             rdata_oe_o,
    output logic             rdy_o,
    output logic             boot_o
);
    localparam int DIV = calc_div(CLK_HZ, BAUD);

    logic             tick;
    logic [DBITS-1:0] rx_byte;
    logic             rx_valid;
    logic             rx_ferr;
    logic [DBITS-1:0] held;
    status_t          st;
    logic             boot_q;
    logic             sel_rd;
    logic             ctrl_hit;
    logic             clr_ready;
    logic             clr_err;

    sboot_tick #(.DIV(DIV)) u_tick (
        .clk(clk), .rst(rst), .tick_o(tick)
    );

    sboot_rx_frame u_rx (
        .clk(clk), .rst(rst), .tick_i(tick), .rx_i(rx_i),
        .byte_o(rx_byte), .valid_o(rx_valid), .ferr_o(rx_ferr)
    );

    assign sel_rd    = cs_i && rw_i;
    assign ctrl_hit  = stb_i && cs_i && !rw_i && (addr_i == OFS_CTRL)
                       && ((wdata_i & LEAVE_BOOT_MASK) != '0);
    assign clr_ready = stb_i && (boot_q || (sel_rd && addr_i == OFS_DATA));
    assign clr_err   = stb_i && !boot_q && sel_rd && (addr_i == OFS_STAT);

    sboot_hold u_hold (
        .clk(clk), .rst(rst),
        .byte_i(rx_byte), .valid_i(rx_valid), .ferr_i(rx_ferr),
        .clr_ready_i(clr_ready), .clr_err_i(clr_err),
        .data_o(held), .status_o(st)
    );

    always_ff @(posedge clk) begin
        if (rst)           boot_q <= 1'b1;
        else if (ctrl_hit) boot_q <= 1'b0;
    end

    always_comb begin
        rdata_o = '0;
        if (boot_q) begin
            rdata_o = held;
        end else begin
            case (addr_i)
                OFS_DATA: rdata_o = held;
                OFS_STAT: rdata_o = st;
                OFS_CTRL: rdata_o = LEAVE_BOOT_MASK;
                default:  rdata_o = '0;
            endcase
        end
    end

    assign rdata_oe_o = rw_i && (boot_q || cs_i);
    assign rdy_o      = boot_q ? st.ready : 1'b1;
    assign boot_o     = boot_q;

    // R4: a stepped cycle consumes the byte unless a new one lands at once
    a_r4_step_clears: assert property (@(posedge clk) disable iff (rst)
        (boot_q && stb_i && !rx_valid) |=> !st.ready);

    // R10: once left, boot mode stays off until reset
    a_r10_boot_sticky: assert property (@(posedge clk) disable iff (rst)
        !boot_q |=> !boot_q);
endmodule

// File: tb/tb_serial_step_boot.sv
module tb_serial_step_boot;
    localparam int CLK_HZ = 100_000_000;
    localparam int BAUD   = 115_200;
    localparam int BIT    = 16 * (CLK_HZ / (BAUD * 16));

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_i = 1'b1;
    logic       cs_i = 1'b0;
    logic       rw_i = 1'b1;
    logic [1:0] addr_i = 2'd0;
    logic       stb_i = 1'b0;
    logic [7:0] wdata_i = 8'h00;
    logic [7:0] rdata_o;
    logic       rdata_oe_o, rdy_o, boot_o;

    int n_chk = 0, n_err = 0, cyc = 0;
    bit done = 0;
    bit in_flight = 0;

    // reference model
    bit       m_boot, m_ready, m_ferr, m_ovr;
    logic [7:0] m_data;

    serial_step_boot #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) dut (
        .clk(clk), .rst(rst), .rx_i(rx_i), .cs_i(cs_i), .rw_i(rw_i),
        .addr_i(addr_i), .stb_i(stb_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .rdata_oe_o(rdata_oe_o), .rdy_o(rdy_o), .boot_o(boot_o)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_boot = 1; m_ready = 0; m_ferr = 0; m_ovr = 0; m_data = 8'h00;
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R3/R5/R11 oe", {7'b0, rdata_oe_o}, {7'b0, rw_i && (m_boot || cs_i)});
            chk("R10 boot", {7'b0, boot_o}, {7'b0, m_boot});
            if (!m_boot)
                chk("R11 rdy held high", {7'b0, rdy_o}, 8'h01);
            else if (!in_flight) begin
                chk("R2 rdy follows ready", {7'b0, rdy_o}, {7'b0, m_ready});
                if (rw_i) chk("R3 boot read byte", rdata_o, m_data);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            done = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog actual=%0d expected<190000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic do_reset();
        @(posedge clk); #1; rst = 1;
        repeat (4) @(posedge clk);
        #1; rst = 0; model_reset();
    endtask

    task automatic send_byte(input logic [7:0] b, input bit stop_ok);
        logic [9:0] fr;
        fr = {stop_ok ? 1'b1 : 1'b0, b, 1'b0};
        @(posedge clk); #1; in_flight = 1;
        for (int i = 0; i < 10; i++) begin
            rx_i = fr[i];
            repeat (BIT) @(posedge clk);
            #1;
        end
        rx_i = 1'b1;
        if (stop_ok) begin
            if (m_ready) m_ovr = 1;
            m_data = b; m_ready = 1;
        end else begin
            m_ferr = 1;
        end
        repeat (BIT) @(posedge clk);   // idle gap lets a bad-stop frame settle
        #1; in_flight = 0;
    endtask

    task automatic bus_cycle(input logic rw, input logic cs, input logic [1:0] a,
                             input logic [7:0] wd, input bit chk_rd,
                             input logic [7:0] exp_rd, input logic exp_oe,
                             input string tag);
        @(posedge clk); #2;
        rw_i = rw; cs_i = cs; addr_i = a; wdata_i = wd; stb_i = 1;
        #1;
        chk({tag, " oe"}, {7'b0, rdata_oe_o}, {7'b0, exp_oe});
        if (chk_rd) chk({tag, " data"}, rdata_o, exp_rd);
        @(posedge clk); #1;
        if (m_boot || (cs && rw && a == 2'd0)) m_ready = 0;
        if (!m_boot && cs && rw && a == 2'd1) begin m_ferr = 0; m_ovr = 0; end
        if (cs && !rw && a == 2'd2 && wd[7]) m_boot = 0;
        stb_i = 0; rw_i = 1; cs_i = 0; addr_i = 2'd0; wdata_i = 8'h00;
    endtask

    initial begin
        model_reset();
        do_reset();
        // R12 reset state
        #2;
        chk("R12 reset rdy", {7'b0, rdy_o}, 8'h00);
        chk("R12 reset boot", {7'b0, boot_o}, 8'h01);

        // R1/R2/R3/R4: one byte steps one read cycle, cs ignored
        send_byte(8'hA9, 1);
        chk("R2 rdy after byte", {7'b0, rdy_o}, 8'h01);
        bus_cycle(1, 0, 2'd3, 8'h00, 1, 8'hA9, 1, "R3 read cs=0");
        #1 chk("R4 rdy cleared by step", {7'b0, rdy_o}, 8'h00);

        // R5: write cycle does not drive bus, still consumes the step
        send_byte(8'h5C, 1);
        bus_cycle(0, 1, 2'd0, 8'h11, 0, 8'h00, 0, "R5 boot write");
        #1 chk("R4 rdy cleared by write step", {7'b0, rdy_o}, 8'h00);

        // R7: back-to-back bytes, newest wins
        send_byte(8'h3E, 1);
        send_byte(8'hC1, 1);
        bus_cycle(1, 1, 2'd1, 8'h00, 1, 8'hC1, 1, "R7 replaced byte");

        // R10: bit7 clear does not leave boot
        send_byte(8'h00, 1);
        bus_cycle(0, 1, 2'd2, 8'h7F, 0, 8'h00, 0, "R10 ctrl no bit7");
        #1 chk("R10 still boot", {7'b0, boot_o}, 8'h01);

        // R10: bit7 set leaves boot
        send_byte(8'h8D, 1);
        bus_cycle(0, 1, 2'd2, 8'h80, 0, 8'h00, 0, "R10 ctrl leave");
        #1 chk("R10 left boot", {7'b0, boot_o}, 8'h00);
        chk("R11 rdy high no data", {7'b0, rdy_o}, 8'h01);

        // R9: status shows overrun left from boot, then clears
        bus_cycle(1, 1, 2'd1, 8'h00, 1, 8'h04, 1, "R9 status ovr");
        bus_cycle(1, 1, 2'd1, 8'h00, 1, 8'h00, 1, "R9 status cleared");

        // R1/R8: normal receive, data read clears ready
        send_byte(8'h96, 1);
        bus_cycle(1, 1, 2'd1, 8'h00, 1, 8'h01, 1, "R9 status ready");
        bus_cycle(1, 1, 2'd0, 8'h00, 1, 8'h96, 1, "R8 data read");
        bus_cycle(1, 1, 2'd1, 8'h00, 1, 8'h00, 1, "R8 ready cleared");

        // R11: unselected read does not drive
        bus_cycle(1, 0, 2'd0, 8'h00, 0, 8'h00, 0, "R11 unselected read");

        // R6: bad stop bit discards the byte
        send_byte(8'h55, 0);
        bus_cycle(1, 1, 2'd1, 8'h00, 1, 8'h02, 1, "R6 status ferr");
        bus_cycle(1, 1, 2'd0, 8'h00, 1, 8'h96, 1, "R6 data unchanged");
        bus_cycle(1, 1, 2'd1, 8'h00, 1, 8'h00, 1, "R9 ferr cleared");

        // R10: writing zero cannot re-enter boot
        bus_cycle(0, 1, 2'd2, 8'h00, 0, 8'h00, 0, "R10 ctrl zero");
        #1 chk("R10 stays normal", {7'b0, boot_o}, 8'h00);

        // R12: reset restores boot mode
        do_reset();
        #2;
        chk("R12 boot after reset", {7'b0, boot_o}, 8'h01);
        chk("R12 rdy after reset", {7'b0, rdy_o}, 8'h00);

        repeat (4) @(posedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule